// File: doc/BRIEF.md
# Set/Clear GPIO Register Cluster

This block is a cluster of general-purpose IO banks behind a 32-bit register bus. Each bank owns up to 32 lines. It holds an output-enable register and an output-data register for those lines. Software never writes either register as a whole. Writing ones to a "set" address turns the matching bits on, and writing ones to a "clear" address turns them off. Bits written as zero are untouched, so a driver can flip one line without a read-modify-write. The same addresses, when read, show the enable register, the driven data and the synchronised pin levels.

A small decoder in front of the banks splits the address space into 64-byte windows. The lowest window holds a read-only identification word. Bank k sits in window k+1. Windows past the last bank read as zero and ignore writes. Reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is high. The bus carries word addresses: byte offset = 4 × `bus_word`.

Top module: `gpio_cluster`

## Requirements
- R1: While `rst_n` is low at a clock edge, every enable and data bit resets to 0. Every line then sits undriven (`pin_oe` = 0, `pin_out` = 0).
- R2: A write to bank byte offset 0x00 sets each enable bit whose write-data bit is 1. Enable bits written as 0 keep their value. A read of 0x00 returns the enable register.
- R3: A write to bank byte offset 0x04 clears each enable bit whose write-data bit is 1, and leaves the others. A read of 0x04 returns 0.
- R4: A write to bank byte offset 0x08 sets each data bit whose write-data bit is 1, and leaves the others. A read of 0x08 returns the data register.
- R5: A write to bank byte offset 0x0C clears each data bit whose write-data bit is 1, and leaves the others.
- R6: A read of bank byte offset 0x0C returns the bank's `pin_in` levels through a two-stage synchroniser. A level applied before a clock edge is first visible after the second following rising edge. The read is independent of the enables.
- R7: Bank byte offsets 0x10 to 0x3C read as 0, and writes to them change nothing. With no write strobe, no output changes.
- R8: Line n drives `pin_out[n]` = data bit only while its enable is 1, with `pin_oe[n]` = enable. A disabled line has `pin_out[n]` = 0.
- R9: Cluster byte address 0x00 reads the identification word 0x00009370. Byte addresses 0x04 to 0x3C read 0. Writes to this window have no effect.
- R10: Bank k (k = 0, 1, 2) occupies byte base 0x40·(k+1), which is word base 16·(k+1). Its lines are `pin_*[32k+31:32k]`. A write to one bank leaves every other bank unchanged.
- R11: Byte addresses from 0x100 upward read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_word | input | 7 | Word address (byte address / 4) |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | 32 | Write data (set/clear mask) |
| bus_rdata | output | 32 | Combinational read data for `bus_word` |
| pin_in | input | 96 | Raw pin levels, 32 per bank |
| pin_oe | output | 96 | Per-line output enable |
| pin_out | output | 96 | Per-line driven value, 0 while disabled |

## Verification
A wrong enable or data bit shows up on `pin_oe`/`pin_out` in the cycle after the write that corrupted it. It also shows in the combinational readback at 0x00 or 0x08, so one read after each write pins down the bit and the bank. A wrong synchroniser depth shows as the input readback changing one edge early or late. A wrong window decode shows as a write landing in a neighbouring bank or reserved word, and the full-cluster compare after every write reveals it at once.

// File: rtl/gpio_pkg.sv
// Shared definitions for the set/clear GPIO cluster.
// Assumes a 32-bit register bus and 16 word slots per 64-byte window.
package gpio_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned SLOT_W = 4;

    // Word slot inside a bank window; the order is the software contract.
    typedef enum logic [SLOT_W-1:0] {
        SLOT_OE_SET  = 4'd0,   // read: enables, write: set enables
        SLOT_OE_CLR  = 4'd1,   // read: zero,    write: clear enables
        SLOT_DAT_SET = 4'd2,   // read: data,    write: set data
        SLOT_DAT_CLR = 4'd3    // read: pins,    write: clear data
    } slot_e;
endpackage

// File: rtl/gpio_sync.sv
// Two-flop level synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent (no multi-bit coherence is promised).
module gpio_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Purpose: shift raw levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/gpio_bank.sv
// One GPIO bank: enable and data registers changed only through
// write-one-to-set / write-one-to-clear slots, plus synchronised pin readback.
// Assumes the parent decodes the window and hands in sel and a word slot.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int unsigned LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [SLOT_W-1:0] slot,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  oe_q,
    output logic [LINES-1:0]  dat_q
);
    logic [LINES-1:0] pin_s;
    logic [LINES-1:0] mask;
    slot_e            slot_e_w;

    assign mask     = wdata[LINES-1:0];
    assign slot_e_w = slot_e'(slot);

    gpio_sync #(.WIDTH(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_s)
    );

    // Purpose: apply set/clear masks to the enable and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q  <= '0;
            dat_q <= '0;
        end else if (sel && wr) begin
            case (slot_e_w)
                SLOT_OE_SET:  oe_q  <= oe_q | mask;
                SLOT_OE_CLR:  oe_q  <= oe_q & ~mask;
                SLOT_DAT_SET: dat_q <= dat_q | mask;
                SLOT_DAT_CLR: dat_q <= dat_q & ~mask;
                default: ;
            endcase
        end
    end

    // Purpose: select the read view for the addressed slot, zero otherwise.
    always_comb begin
        rdata = '0;
        if (sel) begin
            case (slot_e_w)
                SLOT_OE_SET:  rdata[LINES-1:0] = oe_q;
                SLOT_DAT_SET: rdata[LINES-1:0] = dat_q;
                SLOT_DAT_CLR: rdata[LINES-1:0] = pin_s;
                default:      rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_cluster.sv
// GPIO cluster: window decoder, read-only identification word, and
// NUM_BANKS set/clear GPIO banks. Window 0 holds the ID word, window k+1
// holds bank k. Assumes word addressing and single-cycle writes.
module gpio_cluster
    import gpio_pkg::*;
#(
    parameter int unsigned    NUM_BANKS = 3,
    parameter int unsigned    LINES     = 32,
    parameter int unsigned    ADDR_W    = 7,
    parameter logic [REG_W-1:0] ID_WORD = 32'h0000_9370
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_word,
    input  logic                       bus_wr,
    input  logic [REG_W-1:0]           bus_wdata,
    output logic [REG_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*LINES-1:0] pin_in,
    output logic [NUM_BANKS*LINES-1:0] pin_oe,
    output logic [NUM_BANKS*LINES-1:0] pin_out
);
    localparam int unsigned WIN_W = ADDR_W - SLOT_W;

    logic [WIN_W-1:0]  win;
    logic [SLOT_W-1:0] slot;
    logic [REG_W-1:0]  id_rd;
    logic [REG_W-1:0]  bank_rd [NUM_BANKS];

    assign win  = bus_word[ADDR_W-1:SLOT_W];
    assign slot = bus_word[SLOT_W-1:0];

    // Purpose: identification window, only its first word is non-zero.
    always_comb begin
        id_rd = '0;
        if (win == '0 && slot == '0) id_rd = ID_WORD;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic             sel;
        logic [LINES-1:0] oe_w;
        logic [LINES-1:0] dat_w;

        assign sel = (win == WIN_W'(g + 1));

        gpio_bank #(.LINES(LINES)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (sel),
            .wr     (bus_wr),
            .slot   (slot),
            .wdata  (bus_wdata),
            .rdata  (bank_rd[g]),
            .pin_in (pin_in[g*LINES +: LINES]),
            .oe_q   (oe_w),
            .dat_q  (dat_w)
        );

        assign pin_oe[g*LINES +: LINES]  = oe_w;
        assign pin_out[g*LINES +: LINES] = dat_w & oe_w;
    end

    // Purpose: merge read data, at most one source is non-zero.
    always_comb begin
        bus_rdata = id_rd;
        for (int k = 0; k < NUM_BANKS; k++) bus_rdata = bus_rdata | bank_rd[k];
    end
endmodule

// File: rtl/gpio_cluster_chk.sv
// Port-level property checker for gpio_cluster, attached with bind.
module gpio_cluster_chk #(
    parameter int unsigned      NUM_BANKS = 3,
    parameter int unsigned      LINES     = 32,
    parameter int unsigned      ADDR_W    = 7,
    parameter logic [31:0]      ID_WORD   = 32'h0000_9370
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_word,
    input logic                       bus_wr,
    input logic [31:0]                bus_wdata,
    input logic [31:0]                bus_rdata,
    input logic [NUM_BANKS*LINES-1:0] pin_oe,
    input logic [NUM_BANKS*LINES-1:0] pin_out
);
    localparam int unsigned WIN_W = ADDR_W - 4;

    // R1: reset clears every enable.
    p_reset_r1: assert property (@(posedge clk) !rst_n |=> pin_oe == '0);

    // R8: a disabled line never drives a 1.
    p_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    // R7: without a write strobe, the outputs hold.
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pin_oe) && $stable(pin_out)));

    // R7: reserved slots read zero.
    p_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_word[3:2] != 2'b00) |-> bus_rdata == '0);

    // R9: identification word.
    p_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_word == '0) |-> bus_rdata == ID_WORD);

    // R11: beyond the last bank reads zero.
    p_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_word[ADDR_W-1:4] > WIN_W'(NUM_BANKS)) |-> bus_rdata == '0);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'((g + 1) * 16);

        // R2: set-enable turns on every written one.
        p_oe_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_word == BASE) |=>
            ((pin_oe[g*LINES +: LINES] & $past(bus_wdata[LINES-1:0]))
              == $past(bus_wdata[LINES-1:0])));

        // R3: clear-enable turns off every written one.
        p_oe_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_word == BASE + ADDR_W'(1)) |=>
            ((pin_oe[g*LINES +: LINES] & $past(bus_wdata[LINES-1:0])) == '0));

        // R5: clear-data leaves written lines at 0.
        p_dat_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_word == BASE + ADDR_W'(3)) |=>
            ((pin_out[g*LINES +: LINES] & $past(bus_wdata[LINES-1:0])) == '0));
    end
endmodule

bind gpio_cluster gpio_cluster_chk #(
    .NUM_BANKS (NUM_BANKS),
    .LINES     (LINES),
    .ADDR_W    (ADDR_W),
    .ID_WORD   (ID_WORD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_word  (bus_word),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
);

// File: tb/test_gpio_cluster.sv
// Self-checking bench: sweeps every bank, bit and slot against a bench model.
module test_gpio_cluster;
    localparam int NB = 3;
    localparam int L  = 32;
    localparam int AW = 7;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [AW-1:0]   bus_word;
    logic            bus_wr;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [NB*L-1:0] pin_in;
    logic [NB*L-1:0] pin_oe;
    logic [NB*L-1:0] pin_out;

    always #10 clk = ~clk;

    gpio_cluster i_gpio_cluster (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    logic [31:0] m_oe  [NB];
    logic [31:0] m_dat [NB];
    logic [31:0] seed  = 32'h1234_5679;

    function automatic logic [AW-1:0] base(int b);
        return AW'((b + 1) * 16);
    endfunction

    task automatic next_rand(output logic [31:0] r);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        r = seed;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_word  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_word = a;
        #1 d = bus_rdata;
    endtask

    task automatic check_all(string req);
        logic [31:0] v;
        for (int b = 0; b < NB; b++) begin
            chk({req, " R8 pin_oe"},  pin_oe[b*L +: L],  m_oe[b]);
            chk({req, " R8 pin_out"}, pin_out[b*L +: L], m_dat[b] & m_oe[b]);
            rd(base(b),                v); chk({req, " R2 read oe"},  v, m_oe[b]);
            rd(base(b) + AW'(1),       v); chk({req, " R3 read 0x04"}, v, 32'h0);
            rd(base(b) + AW'(2),       v); chk({req, " R4 read data"}, v, m_dat[b]);
        end
    endtask

    task automatic apply(int b, int op, logic [31:0] p);
        wr(base(b) + AW'(op), p);
        case (op)
            0: m_oe[b]  = m_oe[b] | p;
            1: m_oe[b]  = m_oe[b] & ~p;
            2: m_dat[b] = m_dat[b] | p;
            default: m_dat[b] = m_dat[b] & ~p;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] r;
        logic [31:0] prev;
        rst_n = 1'b0; bus_wr = 1'b0; bus_word = '0; bus_wdata = '0; pin_in = '0;
        for (int b = 0; b < NB; b++) begin m_oe[b] = '0; m_dat[b] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        check_all("R1 reset");

        // R9: identification window.
        rd('0, v); chk("R9 id word", v, 32'h0000_9370);
        for (int w = 1; w < 16; w++) begin rd(AW'(w), v); chk("R9 id window zero", v, 32'h0); end
        for (int w = 0; w < 16; w++) wr(AW'(w), 32'hFFFF_FFFF);
        rd('0, v); chk("R9 id after write", v, 32'h0000_9370);
        check_all("R9 write ignored");

        // R2 R3 R4 R5: walking single bits per bank.
        for (int b = 0; b < NB; b++) begin
            for (int op = 0; op < 4; op++) begin
                for (int i = 0; i < L; i++) begin
                    apply(b, op, 32'h1 << i);
                    chk("R2 R3 R4 R5 walk oe", pin_oe[b*L +: L], m_oe[b]);
                    chk("R8 walk out", pin_out[b*L +: L], m_dat[b] & m_oe[b]);
                end
                check_all("R10 walk");
            end
        end

        // R2 R3 R4 R5 R10: random masks, zero bits must leave state alone.
        for (int i = 0; i < 200; i++) begin
            next_rand(r);
            next_rand(v);
            apply(int'(r[1:0] % 2'd3 + ((r[3:2] == 2'b11) ? 2'd0 : 2'd0)) % NB, int'(r[5:4]), v);
            check_all("R10 random");
        end

        // R7: reserved slots in every bank.
        for (int b = 0; b < NB; b++) begin
            for (int s = 4; s < 16; s++) begin
                wr(base(b) + AW'(s), 32'hFFFF_FFFF);
                rd(base(b) + AW'(s), v); chk("R7 reserved read", v, 32'h0);
                chk("R7 reserved oe", pin_oe[b*L +: L], m_oe[b]);
                chk("R7 reserved out", pin_out[b*L +: L], m_dat[b] & m_oe[b]);
            end
        end
        check_all("R7 after reserved");

        // R11: out-of-range windows.
        for (int w = 16 * (NB + 1); w < (1 << AW); w++) begin
            wr(AW'(w), 32'hFFFF_FFFF);
            rd(AW'(w), v); chk("R11 out of range read", v, 32'h0);
        end
        check_all("R11 after writes");

        // R6: two-edge input latency, walking patterns per bank.
        for (int b = 0; b < NB; b++) begin
            prev = '0;
            for (int i = 0; i <= L; i++) begin
                logic [31:0] pat;
                pat = (i == L) ? 32'hA5C3_0F96 : ~(32'h1 << i) ^ {32{b[0]}};
                @(negedge clk);
                pin_in[b*L +: L] = pat;
                bus_word = base(b) + AW'(3);
                #1 chk("R6 before edge", bus_rdata, prev);
                @(negedge clk);
                #1 chk("R6 after one edge", bus_rdata, prev);
                @(negedge clk);
                #1 chk("R6 after two edges", bus_rdata, pat);
                prev = pat;
            end
        end
        check_all("R6 pins do not touch registers");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule